// File: doc/BRIEF.md
# Vector carry-out mask generator

This block produces the carry-out (add form) or the borrow-out (subtract form) of a multi-word vector add or subtract, one result bit per element. For element `i` it combines source operand two, source operand one (or a scalar broadcast to every element) and an incoming carry or borrow bit. It then stores the outgoing bit into a packed destination mask. The incoming bit comes from a carry mask register, and that register uses the same packing as the destination.

A `start_i` pulse launches a run over the whole register group. The block walks the element index from 0 to `vlmax-1` and presents that index on an element read port. It reads the 64-bit mask word that holds the current element's field from both the carry mask and the destination mask. It computes the new destination word and writes it back one cycle later.

Elements at or above the active length have their fields cleared. A run with an active length of zero writes nothing. When one element's write is still pending and the next element falls in the same mask word, the block waits one cycle so that it never builds a word from stale contents. A one-cycle `done_o` pulse closes each run.

Top module: `vcm_mask_gen`

## Requirements
- R1: With `sub_i`=0, the result bit for an active element is 1 exactly when the full-precision sum of the low-SEW-bit operands plus the carry-in does not fit in SEW bits. The carry-in is the carry-mask bit at the element's field offset. `sew_i` encodes SEW as 0=8, 1=16, 2=32, 3=64.
- R2: With `sub_i`=1, the result bit for an active element is 1 exactly when, as unsigned numbers on the low SEW bits, operand two is less than operand one (borrow-in 0) or less than or equal to operand one (borrow-in 1).
- R3: With `use_scalar_i`=1, `scalar_i` takes the place of operand one. It is sign-extended from XLEN bits to 64 bits and then cut to SEW bits. Operand bits above SEW never affect a result.
- R4: `mlen_log2_i` (0..6) sets the field width to MLEN=2^`mlen_log2_i`. The field of element i lies in mask word (i·MLEN)/64 at bit offset (i·MLEN) mod 64. It receives the result bit zero-extended to MLEN bits, and every other bit of that word keeps its value.
- R5: When the active length is nonzero, the fields of elements `vl_i` through `vlmax_i`-1 are written as all zeros.
- R6: A start with `vl_i`=0 performs no mask write and raises `done_o` in the cycle after the start.
- R7: An element whose mask word differs from that of the previous element is read in the cycle right after the previous one. An element that shares its word with the previous one is read one cycle later than that. Two consecutive write cycles never target the same word. `done_o` is a one-cycle pulse in the cycle after the last write.
- R8: During reset, `busy_o`, `done_o` and `mwr_en_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run; taken only while idle |
| sub_i | input | 1 | 0 = carry-out of add, 1 = borrow-out of subtract |
| use_scalar_i | input | 1 | Use `scalar_i` instead of operand one |
| sew_i | input | 2 | Element width code (8/16/32/64) |
| mlen_log2_i | input | 3 | log2 of the mask field width |
| vl_i | input | CNT_W | Active element count |
| vlmax_i | input | CNT_W | Elements in the register group |
| scalar_i | input | XLEN | Scalar operand |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| elem_idx_o | output | EI_W | Element being read |
| src1_i | input | 64 | Operand one of that element, right-aligned |
| src2_i | input | 64 | Operand two of that element, right-aligned |
| mword_idx_o | output | EI_W | Mask word holding the element's field |
| carry_word_i | input | 64 | Carry mask word at `mword_idx_o` |
| dst_word_i | input | 64 | Destination mask word at `mword_idx_o` |
| mwr_en_o | output | 1 | Destination word write enable |
| mwr_idx_o | output | EI_W | Destination word index |
| mwr_data_o | output | 64 | Destination word data |

## Verification
A read of one element's mask word and the write-back of the previous element's word can fall in the same cycle. When both target one word, this is a read-after-write hazard. Narrow fields (MLEN of 1 and 4) pack many consecutive elements into one word, which forces this overlap again and again. A field width of 64 puts every element in its own word, so no stalls occur. The outcome is judged by comparing the final destination memory with an arithmetic model, by counting the cycles until `done_o` against the number of expected stalls, and by a property that forbids two consecutive writes to the same word.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned OFF_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } vcm_state_e;

  typedef struct packed {
    logic       sub;
    logic       use_scalar;
    logic [1:0] sew;
    logic [2:0] mlen_log2;
  } vcm_cfg_t;
endpackage

// File: rtl/vcm_lane.sv
module vcm_lane #(
  parameter int unsigned N_WIDTHS = 4
) (
  input  logic [1:0]  sew_i,
  input  logic        sub_i,
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic        cin_i,
  output logic        cout_o
);
  logic [N_WIDTHS-1:0] flag;

  // one extended adder/subtractor per element width; top bit is carry or sign
  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_w
    localparam int unsigned W = 8 << g;
    logic [W:0] sum;
    logic [W:0] dif;
    assign sum = {1'b0, a_i[W-1:0]} + {1'b0, b_i[W-1:0]} + (W+1)'(cin_i);
    assign dif = {1'b0, a_i[W-1:0]} - {1'b0, b_i[W-1:0]} - (W+1)'(cin_i);
    assign flag[g] = sub_i ? dif[W] : sum[W];
  end

  assign cout_o = flag[sew_i];
endmodule

// File: rtl/vcm_deposit.sv
module vcm_deposit import vcm_pkg::*; (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        mlen_log2_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] fmask;

  always_comb begin
    if (mlen_log2_i >= 3'd6) fmask = '1;
    else                     fmask = (64'd1 << (7'd1 << mlen_log2_i)) - 64'd1;
  end

  assign word_o = (word_i & ~(fmask << off_i)) | (64'(bit_i) << off_i);
endmodule

// File: rtl/vcm_seq.sv
module vcm_seq import vcm_pkg::*; #(
  parameter int unsigned EI_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            empty_i,
  input  logic            last_i,
  input  logic            hazard_i,
  output logic            fire_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [EI_W-1:0] elem_o
);
  vcm_state_e      state_q;
  logic [EI_W-1:0] elem_q;
  logic            done_q;

  assign fire_o = (state_q == ST_RUN) && !hazard_i;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign elem_o = elem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            elem_q <= '0;
            if (empty_i) done_q  <= 1'b1;
            else         state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (fire_o) begin
            if (last_i) state_q <= ST_DRAIN;
            else        elem_q  <= elem_q + 1'b1;
          end
        end
        ST_DRAIN: begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcm_mask_gen.sv
module vcm_mask_gen import vcm_pkg::*; #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned MAX_ELEMS = 64,
  localparam int unsigned EI_W     = $clog2(MAX_ELEMS),
  localparam int unsigned CNT_W    = $clog2(MAX_ELEMS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              use_scalar_i,
  input  logic [1:0]        sew_i,
  input  logic [2:0]        mlen_log2_i,
  input  logic [CNT_W-1:0]  vl_i,
  input  logic [CNT_W-1:0]  vlmax_i,
  input  logic [XLEN-1:0]   scalar_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [EI_W-1:0]   elem_idx_o,
  input  logic [63:0]       src1_i,
  input  logic [63:0]       src2_i,
  output logic [EI_W-1:0]   mword_idx_o,
  input  logic [63:0]       carry_word_i,
  input  logic [63:0]       dst_word_i,
  output logic              mwr_en_o,
  output logic [EI_W-1:0]   mwr_idx_o,
  output logic [63:0]       mwr_data_o
);
  localparam int unsigned POS_W = EI_W + OFF_W;

  vcm_cfg_t          cfg_q;
  logic [CNT_W-1:0]  vl_q, vlmax_q;
  logic [XLEN-1:0]   scalar_q;

  logic              fire, hazard, last, cout, res_bit, active;
  logic [EI_W-1:0]   elem;
  logic [POS_W-1:0]  pos;
  logic [EI_W-1:0]   cur_widx;
  logic [OFF_W-1:0]  off;
  logic [63:0]       scalar_x, op_b, new_word;

  logic              wv_q;
  logic [EI_W-1:0]   widx_q;
  logic [63:0]       wdata_q;

  // run configuration, captured on an accepted start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      vl_q     <= '0;
      vlmax_q  <= '0;
      scalar_q <= '0;
    end else if (start_i && !busy_o) begin
      cfg_q    <= '{sub: sub_i, use_scalar: use_scalar_i, sew: sew_i, mlen_log2: mlen_log2_i};
      vl_q     <= vl_i;
      vlmax_q  <= vlmax_i;
      scalar_q <= scalar_i;
    end
  end

  vcm_seq #(.EI_W(EI_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .empty_i  (vl_i == '0),
    .last_i   (last),
    .hazard_i (hazard),
    .fire_o   (fire),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .elem_o   (elem)
  );

  // field placement of the current element
  assign pos      = POS_W'(elem) << cfg_q.mlen_log2;
  assign cur_widx = pos[POS_W-1:OFF_W];
  assign off      = pos[OFF_W-1:0];
  assign last     = (CNT_W'(elem) == vlmax_q - 1'b1);
  assign active   = (CNT_W'(elem) < vl_q);

  // stale-read guard: the pending write targets the word being read
  assign hazard   = wv_q && (widx_q == cur_widx);

  assign scalar_x = 64'($signed(scalar_q));
  assign op_b     = cfg_q.use_scalar ? scalar_x : src1_i;

  vcm_lane u_lane (
    .sew_i  (cfg_q.sew),
    .sub_i  (cfg_q.sub),
    .a_i    (src2_i),
    .b_i    (op_b),
    .cin_i  (carry_word_i[off]),
    .cout_o (cout)
  );

  assign res_bit = active & cout;

  vcm_deposit u_dep (
    .word_i      (dst_word_i),
    .off_i       (off),
    .mlen_log2_i (cfg_q.mlen_log2),
    .bit_i       (res_bit),
    .word_o      (new_word)
  );

  // write-back stage: second half of the read-modify-write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wv_q    <= 1'b0;
      widx_q  <= '0;
      wdata_q <= '0;
    end else begin
      wv_q <= fire;
      if (fire) begin
        widx_q  <= cur_widx;
        wdata_q <= new_word;
      end
    end
  end

  assign elem_idx_o  = elem;
  assign mword_idx_o = cur_widx;
  assign mwr_en_o    = wv_q;
  assign mwr_idx_o   = widx_q;
  assign mwr_data_o  = wdata_q;
endmodule

// File: rtl/vcm_mask_gen_chk.sv
module vcm_mask_gen_chk #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned EI_W  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] vl_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             mwr_en_o,
  input logic [EI_W-1:0]  mwr_idx_o
);
  logic            prev_en;
  logic [EI_W-1:0] prev_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_en  <= 1'b0;
      prev_idx <= '0;
    end else begin
      prev_en  <= mwr_en_o;
      prev_idx <= mwr_idx_o;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R7

  AST_NO_SAME_WORD_B2B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mwr_en_o && prev_en) |-> (mwr_idx_o != prev_idx)); // R7

  AST_WRITE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mwr_en_o |-> busy_o); // R7

  AST_EMPTY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && vl_i == '0) |=> (done_o && !mwr_en_o && !busy_o)); // R6
endmodule

bind vcm_mask_gen vcm_mask_gen_chk #(.CNT_W(CNT_W), .EI_W(EI_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .vl_i      (vl_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .mwr_en_o  (mwr_en_o),
  .mwr_idx_o (mwr_idx_o)
);

// File: tb/sim_vcm_mask_gen.sv
module sim_vcm_mask_gen;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int MAX_ELEMS  = 64;
  localparam int EI_W       = 6;
  localparam int CNT_W      = 7;
  localparam int WD_LIMIT   = 190000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic             sub_i = 1'b0;
  logic             use_scalar_i = 1'b0;
  logic [1:0]       sew_i = '0;
  logic [2:0]       mlen_log2_i = '0;
  logic [CNT_W-1:0] vl_i = '0;
  logic [CNT_W-1:0] vlmax_i = '0;
  logic [XLEN-1:0]  scalar_i = '0;
  logic             busy_o, done_o, mwr_en_o;
  logic [EI_W-1:0]  elem_idx_o, mword_idx_o, mwr_idx_o;
  logic [63:0]      src1_i, src2_i, carry_word_i, dst_word_i, mwr_data_o;

  logic [63:0] src1_mem [MAX_ELEMS];
  logic [63:0] src2_mem [MAX_ELEMS];
  logic [63:0] v0_mem   [MAX_ELEMS];
  logic [63:0] dst_mem  [MAX_ELEMS];
  logic [63:0] dst_init [MAX_ELEMS];
  logic [63:0] exp_mem  [MAX_ELEMS];
  logic        load_q = 1'b0;
  int          wr_cnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vcm_mask_gen #(.XLEN(XLEN), .MAX_ELEMS(MAX_ELEMS)) u0 (.*);

  assign src1_i       = src1_mem[elem_idx_o];
  assign src2_i       = src2_mem[elem_idx_o];
  assign carry_word_i = v0_mem[mword_idx_o];
  assign dst_word_i   = dst_mem[mword_idx_o];

  always @(posedge clk_i) begin
    if (load_q) begin
      for (int k = 0; k < MAX_ELEMS; k++) dst_mem[k] <= dst_init[k];
      wr_cnt <= 0;
    end else if (mwr_en_o) begin
      dst_mem[mwr_idx_o] <= mwr_data_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ref_bit(input logic sub, input int sew, input logic [63:0] a,
                                   input logic [63:0] b, input logic c);
    logic [63:0] msk, am, bm, s;
    msk = (sew == 3) ? '1 : ((64'd1 << (8 << sew)) - 64'd1);
    am = a & msk;
    bm = b & msk;
    if (!sub) begin
      s = (am + bm + 64'(c)) & msk;
      return c ? (s <= am) : (s < am);
    end
    return c ? (am <= bm) : (am < bm);
  endfunction

  task automatic run(input logic sub, input logic scal, input int sew, input int m,
                     input int vl, input int vlmax, input logic [XLEN-1:0] sval);
    logic [63:0] fm, b, got;
    int w, off, n, rexp, bad;
    logic bt;
    string tag;
    for (int i = 0; i < MAX_ELEMS; i++) begin
      src2_mem[i] = {$urandom, $urandom};
      src1_mem[i] = {$urandom, $urandom};
      if (i % 4 == 0) begin src2_mem[i] = '1; src1_mem[i] = '0; end
      if (i % 4 == 1) src1_mem[i] = src2_mem[i];
      v0_mem[i]   = {$urandom, $urandom};
      dst_init[i] = {$urandom, $urandom};
      exp_mem[i]  = dst_init[i];
    end
    fm = (m == 6) ? '1 : ((64'd1 << (1 << m)) - 64'd1);
    if (vl > 0) begin
      for (int i = 0; i < vlmax; i++) begin
        w   = (i << m) >> 6;
        off = (i << m) & 63;
        b   = scal ? {{(64-XLEN){sval[XLEN-1]}}, sval} : src1_mem[i];
        bt  = (i < vl) ? ref_bit(sub, sew, src2_mem[i], b, v0_mem[w][off]) : 1'b0;
        exp_mem[w] = (exp_mem[w] & ~(fm << off)) | (64'(bt) << off);
      end
    end
    rexp = vlmax;
    for (int e = 1; e < vlmax; e++)
      if (((e << m) >> 6) == (((e - 1) << m) >> 6)) rexp++;

    @(negedge clk_i) load_q = 1'b1;
    @(negedge clk_i) load_q = 1'b0;
    sub_i = sub; use_scalar_i = scal; sew_i = 2'(sew); mlen_log2_i = 3'(m);
    vl_i = CNT_W'(vl); vlmax_i = CNT_W'(vlmax); scalar_i = sval; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) start_i = 1'b0;
    n = 1;
    while (!done_o && n < 400) begin
      @(posedge clk_i);
      @(negedge clk_i);
      n++;
    end

    tag = scal ? "R3" : (sub ? "R2" : "R1");
    bad = -1;
    for (int k = MAX_ELEMS - 1; k >= 0; k--) if (dst_mem[k] !== exp_mem[k]) bad = k;
    if (bad < 0) chk(1'b1, tag, '0, '0, "mask memory");
    else chk(1'b0, tag, dst_mem[bad], exp_mem[bad], $sformatf("mask word %0d", bad));

    if (vl == 0) begin
      chk(n == 1 && wr_cnt == 0, "R6", 64'(n * 1000 + wr_cnt), 64'(1000), "cycles*1000+writes");
    end else begin
      chk(n == rexp + 2, "R7", 64'(n), 64'(rexp + 2), "cycles to done");
      // active fields: result bit zero-extended
      bad = 0;
      got = '0;
      for (int i = 0; i < vl; i++) begin
        w = (i << m) >> 6; off = (i << m) & 63;
        if (((dst_mem[w] >> off) & fm) !== ((exp_mem[w] >> off) & fm)) begin
          bad = 1; got = (dst_mem[w] >> off) & fm;
        end
      end
      chk(bad == 0, "R4", got, '0, "active field contents");
      if (vl < vlmax) begin
        bad = 0;
        got = '0;
        for (int i = vl; i < vlmax; i++) begin
          w = (i << m) >> 6; off = (i << m) & 63;
          if (((dst_mem[w] >> off) & fm) != '0) begin bad = 1; got = (dst_mem[w] >> off) & fm; end
        end
        chk(bad == 0, "R5", got, '0, "tail field");
      end
    end
  endtask

  initial begin
    logic [XLEN-1:0] sv;
    int m, vl;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mwr_en_o, "R8",
        {61'b0, busy_o, done_o, mwr_en_o}, '0, "reset outputs");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !mwr_en_o, "R8",
        {61'b0, busy_o, done_o, mwr_en_o}, '0, "idle after reset");
    for (int sew = 0; sew < 4; sew++)
      for (int sub = 0; sub < 2; sub++)
        for (int scal = 0; scal < 2; scal++)
          for (int mi = 0; mi < 3; mi++)
            for (int vi = 0; vi < 4; vi++) begin
              m  = (mi == 0) ? 0 : ((mi == 1) ? 2 : 6);
              vl = (vi == 0) ? 0 : ((vi == 1) ? 1 : ((vi == 2) ? 23 : 40));
              case ((sew + mi + vi) % 4)
                0:       sv = '1;
                1:       sv = {1'b1, {(XLEN-1){1'b0}}};
                2:       sv = XLEN'(1);
                default: sv = XLEN'($urandom);
              endcase
              run(1'(sub), 1'(scal), sew, m, vl, 40, sv);
            end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule